// File: doc/BRIEF.md
# Receive Frame Length and CRC Checker

This block sits on the receive byte stream after the preamble and start-of-frame delimiter have been removed. While the data-valid input is high, one byte arrives on each clock. The block counts the bytes and runs an Ethernet CRC-32 over all of them, including the trailing frame check sequence. When data-valid drops, it reports the true total length and three flags: too short, too long and CRC mismatch.

Accepted bytes are forwarded with one cycle of latency. A programmable maximum length limits how many bytes go downstream. With the huge-frame control clear, bytes past that limit are dropped. With it set, the whole frame is forwarded. In both modes an oversized frame raises the long flag and a one-cycle babbling-receiver event. Downstream logic uses the done pulse and its status word to close out the frame.

Top module: `rx_frame_checker`

## Requirements
- R1: After reset, and until the first frame ends, `fwd_vld`, `babble_evt`, `frm_done`, `stat_len`, `stat_short`, `stat_long` and `stat_crc_err` are all zero.
- R2: A frame starts on the first cycle with `rx_vld` high and ends on the first following cycle with `rx_vld` low. `frm_done` is high for exactly one cycle, on the cycle after that low cycle is sampled. All status outputs are zero whenever `frm_done` is low.
- R3: `stat_len` equals the number of bytes received in the frame, FCS included, even when some bytes were not forwarded.
- R4: `stat_short` is 1 when the length is below `MIN_LEN` (default 64). A frame of exactly `MIN_LEN` bytes is not short.
- R5: `stat_long` is 1 when the length is greater than `cfg_max_len`. A frame of exactly `cfg_max_len` bytes is not long.
- R6: The CRC is the reflected CRC-32 with polynomial 0x04C11DB7 and an all-ones start value. Data bits are taken LSB first. The FCS is the complemented CRC, sent low byte first. `stat_crc_err` is 1 when the register after the last byte differs from the good-frame residue 0xC704DD7B (MSB-first notation).
- R7: `babble_evt` pulses high for one cycle, in the cycle after the first byte beyond `cfg_max_len` is received. It fires at most once per frame and only in frames that end with `stat_long` set.
- R8: With `cfg_huge` = 0, the first `cfg_max_len` bytes of a frame appear on `fwd_byte` in order, with `fwd_vld` high one cycle after each is received. Later bytes of the frame are not forwarded.
- R9: With `cfg_huge` = 1, every byte is forwarded, and oversized frames still raise `stat_long` and `babble_evt`.
- R10: Length, CRC and forwarding state restart at each frame start, including when only one idle cycle separates two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_vld | input | 1 | Byte present and frame active |
| rx_byte | input | 8 | Received byte |
| cfg_huge | input | 1 | 1: forward oversized frames in full |
| cfg_max_len | input | LEN_W | Maximum frame length in bytes |
| fwd_vld | output | 1 | Forwarded byte valid |
| fwd_byte | output | 8 | Forwarded byte |
| babble_evt | output | 1 | Oversize event pulse |
| frm_done | output | 1 | Frame end pulse, status valid |
| stat_len | output | LEN_W | Total frame length |
| stat_short | output | 1 | Frame below minimum length |
| stat_long | output | 1 | Frame above maximum length |
| stat_crc_err | output | 1 | CRC residue mismatch |

## Verification
The bench targets the length thresholds from both sides: 63 and 64 bytes for the short flag, and 100 and 101 bytes against a maximum of 100. An off-by-one comparison would flag a legal frame or miss a bad one. Oversized frames are sent in both huge-frame modes. A design that drops the byte at the limit, leaks bytes past it, or reports the truncated length instead of the true one produces a forward count or length mismatch. Frames separated by a single idle cycle check that a counter or CRC register that fails to restart is caught. A corrupted FCS shows whether the residue comparison works.

// File: rtl/rxck_pkg.sv
package rxck_pkg;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT      = 32'hFFFFFFFF;
  // good-frame residue held in reflected register form (0xC704DD7B bit-reversed)
  localparam logic [31:0] CRC_RESIDUE   = 32'hDEBB20E3;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

  function automatic logic [15:0] sat_inc16(input logic [15:0] v);
    return (v == 16'hFFFF) ? v : v + 16'd1;
  endfunction
endpackage

// File: rtl/rxck_len_ctr.sv
module rxck_len_ctr #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic             frame_start,
  input  logic             cfg_huge,
  input  logic [LEN_W-1:0] cfg_max_len,
  output logic [LEN_W-1:0] byte_cnt,
  output logic             over_now,
  output logic             fwd_ok
);
  localparam logic [LEN_W-1:0] CNT_MAX = '1;

  logic [LEN_W-1:0] idx;

  // index of the byte on the input this cycle
  assign idx      = frame_start ? '0 : byte_cnt;
  assign over_now = byte_vld && (idx == cfg_max_len);
  assign fwd_ok   = byte_vld && (cfg_huge || (idx < cfg_max_len));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) byte_cnt <= '0;
    else if (byte_vld) byte_cnt <= (idx == CNT_MAX) ? idx : idx + 1'b1;
  end
endmodule

// File: rtl/rxck_crc.sv
module rxck_crc
  import rxck_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld,
  input  logic       frame_start,
  input  logic [7:0] data,
  output logic       crc_ok
);
  logic [31:0] crc_q;
  logic [31:0] seed;

  assign seed   = frame_start ? CRC_INIT : crc_q;
  assign crc_ok = (crc_q == CRC_RESIDUE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_INIT;
    else if (byte_vld) crc_q <= crc_step(seed, data);
  end
endmodule

// File: rtl/rx_frame_checker.sv
module rx_frame_checker #(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_vld,
  input  logic [7:0]       rx_byte,
  input  logic             cfg_huge,
  input  logic [LEN_W-1:0] cfg_max_len,
  output logic             fwd_vld,
  output logic [7:0]       fwd_byte,
  output logic             babble_evt,
  output logic             frm_done,
  output logic [LEN_W-1:0] stat_len,
  output logic             stat_short,
  output logic             stat_long,
  output logic             stat_crc_err
);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);

  logic             in_frame;
  logic             frame_start;
  logic             frame_end;
  logic [LEN_W-1:0] byte_cnt;
  logic             over_now;
  logic             fwd_ok;
  logic             crc_ok;

  assign frame_start = rx_vld && !in_frame;
  assign frame_end   = !rx_vld && in_frame;

  rxck_len_ctr #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_n), .byte_vld(rx_vld), .frame_start(frame_start),
    .cfg_huge(cfg_huge), .cfg_max_len(cfg_max_len),
    .byte_cnt(byte_cnt), .over_now(over_now), .fwd_ok(fwd_ok)
  );

  rxck_crc u_crc (
    .clk(clk), .rst_n(rst_n), .byte_vld(rx_vld), .frame_start(frame_start),
    .data(rx_byte), .crc_ok(crc_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame   <= 1'b0;
      fwd_vld    <= 1'b0;
      fwd_byte   <= '0;
      babble_evt <= 1'b0;
    end else begin
      in_frame   <= rx_vld;
      fwd_vld    <= fwd_ok;
      fwd_byte   <= fwd_ok ? rx_byte : '0;
      babble_evt <= over_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_done     <= 1'b0;
      stat_len     <= '0;
      stat_short   <= 1'b0;
      stat_long    <= 1'b0;
      stat_crc_err <= 1'b0;
    end else if (frame_end) begin
      frm_done     <= 1'b1;
      stat_len     <= byte_cnt;
      stat_short   <= byte_cnt < MIN_L;
      stat_long    <= byte_cnt > cfg_max_len;
      stat_crc_err <= !crc_ok;
    end else begin
      frm_done     <= 1'b0;
      stat_len     <= '0;
      stat_short   <= 1'b0;
      stat_long    <= 1'b0;
      stat_crc_err <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_frame_checker_chk.sv
module rx_frame_checker_chk #(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_huge,
  input logic [LEN_W-1:0] cfg_max_len,
  input logic             fwd_vld,
  input logic             babble_evt,
  input logic             frm_done,
  input logic [LEN_W-1:0] stat_len,
  input logic             stat_short,
  input logic             stat_long,
  input logic             stat_crc_err
);
  logic [LEN_W-1:0] fwd_seen;
  logic             babble_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_seen    <= '0;
      babble_seen <= 1'b0;
    end else if (frm_done) begin
      fwd_seen    <= '0;
      babble_seen <= 1'b0;
    end else begin
      if (fwd_vld) fwd_seen <= fwd_seen + 1'b1;
      if (babble_evt) babble_seen <= 1'b1;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |=> !frm_done); // R2
  AST_STATUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_done |-> (stat_len == '0 && !stat_short && !stat_long && !stat_crc_err)); // R2
  AST_SHORT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |-> (stat_short == (stat_len < LEN_W'(MIN_LEN)))); // R4
  AST_LONG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |-> (stat_long == (stat_len > cfg_max_len))); // R5
  AST_BABBLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    babble_evt |=> !babble_evt); // R7
  AST_BABBLE_MATCHES_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |-> (stat_long == babble_seen)); // R7
  AST_NO_FWD_PAST_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_vld && !cfg_huge) |-> (fwd_seen < cfg_max_len)); // R8
endmodule

bind rx_frame_checker rx_frame_checker_chk #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_huge(cfg_huge), .cfg_max_len(cfg_max_len),
  .fwd_vld(fwd_vld), .babble_evt(babble_evt), .frm_done(frm_done),
  .stat_len(stat_len), .stat_short(stat_short), .stat_long(stat_long),
  .stat_crc_err(stat_crc_err)
);

// File: tb/sim_rx_frame_checker.sv
module sim_rx_frame_checker;
  localparam int LEN_W   = 16;
  localparam int MIN_LEN = 64;
  localparam int MAXL    = 100;

  typedef struct {
    int len; bit shrt; bit lng; bit crc_err; int fwd; int babble; int huge;
  } exp_t;

  logic clk = 0, rst_n = 0, rx_vld = 0, cfg_huge = 0;
  logic [7:0] rx_byte = 0;
  logic [LEN_W-1:0] cfg_max_len = LEN_W'(MAXL);
  logic fwd_vld, babble_evt, frm_done, stat_short, stat_long, stat_crc_err;
  logic [7:0] fwd_byte;
  logic [LEN_W-1:0] stat_len;

  int checks = 0, fails = 0;
  int lcg = 12345;
  int n_fwd = 0, n_babble = 0, done_count = 0;
  exp_t exp_q[$];
  logic [7:0] byte_q[$];

  always #5 clk = ~clk;

  rx_frame_checker #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_byte(rx_byte),
    .cfg_huge(cfg_huge), .cfg_max_len(cfg_max_len),
    .fwd_vld(fwd_vld), .fwd_byte(fwd_byte), .babble_evt(babble_evt),
    .frm_done(frm_done), .stat_len(stat_len), .stat_short(stat_short),
    .stat_long(stat_long), .stat_crc_err(stat_crc_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // MSB-first CRC on bit-reversed bytes, an independent form of the same code
  function automatic logic [31:0] crc_msb(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[31] ^ d[i]) r = (r << 1) ^ 32'h04C11DB7;
      else              r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  task automatic send_frame(input int len, input bit good, input bit huge, input int gap);
    logic [7:0] bytes[$];
    logic [31:0] c, fcs;
    exp_t e;
    int fwd_n;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < len - 4; i++) begin
      lcg = lcg * 1103515245 + 12345;
      bytes.push_back(lcg[23:16]);
      c = crc_msb(c, lcg[23:16]);
    end
    fcs = ~rev32(c);
    for (int i = 0; i < 4; i++) bytes.push_back(fcs[8*i +: 8]);
    if (!good) bytes[len-1] = bytes[len-1] ^ 8'h01;
    fwd_n = huge ? len : ((len < MAXL) ? len : MAXL);
    for (int i = 0; i < fwd_n; i++) byte_q.push_back(bytes[i]);
    e.len = len; e.shrt = (len < MIN_LEN); e.lng = (len > MAXL);
    e.crc_err = !good; e.fwd = fwd_n; e.babble = (len > MAXL) ? 1 : 0; e.huge = huge;
    exp_q.push_back(e);
    @(negedge clk);
    cfg_huge = huge;
    for (int i = 0; i < len; i++) begin
      rx_vld = 1; rx_byte = bytes[i];
      @(negedge clk);
    end
    rx_vld = 0; rx_byte = 0;
    for (int i = 1; i < gap; i++) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (fwd_vld) begin
        n_fwd++;
        if (byte_q.size() == 0) check(0, "R8 unexpected forwarded byte", fwd_byte, -1);
        else begin
          logic [7:0] b;
          b = byte_q.pop_front();
          check(fwd_byte == b, "R8/R9 forwarded data", fwd_byte, b);
        end
      end
      if (babble_evt) n_babble++;
      if (frm_done) begin
        done_count++;
        if (exp_q.size() == 0) check(0, "R2 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          check(stat_len == LEN_W'(e.len), "R3 length", stat_len, e.len);
          check(stat_short == e.shrt, "R4 short flag", stat_short, e.shrt);
          check(stat_long == e.lng, "R5 long flag", stat_long, e.lng);
          check(stat_crc_err == e.crc_err, "R6 crc error flag", stat_crc_err, e.crc_err);
          check(n_babble == e.babble, e.huge ? "R9 babble count" : "R7 babble count", n_babble, e.babble);
          check(n_fwd == e.fwd, e.huge ? "R9 forwarded count" : "R8 forwarded count", n_fwd, e.fwd);
        end
        n_fwd = 0; n_babble = 0;
      end else begin
        if (stat_len != 0 || stat_short || stat_long || stat_crc_err)
          check(0, "R2 status outside done", 1, 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check({fwd_vld, babble_evt, frm_done, stat_short, stat_long, stat_crc_err} == 6'b0,
          "R1 reset outputs", {fwd_vld, babble_evt, frm_done}, 0);
    check(stat_len == 0, "R1 reset length", stat_len, 0);
    send_frame(64, 1, 0, 3);   // R4 exactly minimum, good CRC R6
    send_frame(63, 1, 0, 3);   // R4 short
    send_frame(80, 0, 0, 3);   // R6 bad CRC
    send_frame(100, 1, 0, 3);  // R5 exactly max, R8 all forwarded
    send_frame(101, 1, 0, 3);  // R5 R7 R8 one over max, truncated
    send_frame(120, 1, 1, 3);  // R9 huge mode
    send_frame(70, 1, 1, 1);   // R10 one idle cycle gap
    send_frame(65, 0, 0, 1);   // R10 back-to-back, bad CRC
    send_frame(130, 1, 0, 4);  // R8 truncation again after restart
    repeat (5) @(negedge clk);
    check(done_count == 9, "R2 done pulse count", done_count, 9);
    check(exp_q.size() == 0, "R2 pending frames", exp_q.size(), 0);
    check(byte_q.size() == 0, "R8 pending forwarded bytes", byte_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule